// File: doc/BRIEF.md
# Linked Descriptor Walker

This block drives one DMA channel from a chain of transfer descriptors kept in memory. Once it is started with the byte address of the first descriptor, it reads the descriptor one word at a time through a single read port. It checks the valid flag and gives the descriptor's addresses, byte count and per-segment options to a transfer datapath. It then waits for that datapath to report completion. After completion it retires the descriptor by writing its header back with the valid flag cleared, and then either follows the next-link pointer or stops.

A descriptor is eight 32-bit words at consecutive word addresses. Word 0 is the header, and its bit 0 is the valid flag. Word 1 is the source address, word 2 the destination address, word 3 the byte count, word 4 the configuration, and word 7 the byte address of the next descriptor. Words 5 and 6 are fetched but have no effect. Because the header is written back, a ring of descriptors works without extra logic. When the walk comes back to an entry it has already retired, it finds that entry invalid and halts.

Top module: `lnk_desc_walker`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy`, `err_flag`, `rd_req`, `wr_en`, `xfer_start` and `end_irq` are all low.
- R2: A `start` pulse seen while idle makes the block read eight words at `start_addr`, `start_addr`+4, ... `start_addr`+28, in that order. It keeps one request open at a time and holds `rd_addr` steady until `rd_valid`. A `start` seen while busy is ignored.
- R3: `xfer_start` is a one-cycle pulse that comes only after all eight words have been captured. In that pulse `xfer_src`, `xfer_dst` and `xfer_len` carry words 1, 2 and 3.
- R4: If header bit 0 of a fetched descriptor is 0, the block returns to idle without a transfer and without a write-back.
- R5: After `xfer_done`, the block issues one write whose `wr_addr` is the descriptor's first byte address and whose `wr_data` is the header with bit 0 cleared and all other bits unchanged.
- R6: `end_irq` pulses in the write-back cycle only when configuration bit 24 of that descriptor is 0.
- R7: If configuration bit 31 is 1, the next fetch starts at the address in word 7, which may point back to an earlier entry. If bit 31 is 0, the block goes idle after the write-back.
- R8: `xfer_src_fixed` equals configuration bit 20 and `xfer_dst_fixed` equals bit 21.
- R9: The source unit code is configuration bits 15:12 and the destination unit code is bits 19:16. A code n from 0 to 7 gives a unit of 2^n bytes on `xfer_src_unit`/`xfer_dst_unit`. Codes 8 to 15 give 0.
- R10: A read answered with `rd_err` high stops the walk, starts no transfer and sets `err_flag`. `err_flag` stays set until the next accepted `start`, which clears it.
- R11: `busy` is high from the cycle after an accepted `start` until the block halts, and `rd_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a walk at `start_addr` |
| start_addr | input | AW (32) | Byte address of the first descriptor |
| busy | output | 1 | Walk in progress |
| err_flag | output | 1 | Sticky read-error indication |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | AW (32) | Read byte address |
| rd_valid | input | 1 | Read answer present |
| rd_err | input | 1 | Read answer is an error (qualified by `rd_valid`) |
| rd_data | input | DW (32) | Read data |
| wr_en | output | 1 | Header write-back strobe |
| wr_addr | output | AW (32) | Write-back byte address |
| wr_data | output | DW (32) | Retired header value |
| xfer_start | output | 1 | Launch pulse to the transfer datapath |
| xfer_src | output | DW (32) | Source address of the segment |
| xfer_dst | output | DW (32) | Destination address of the segment |
| xfer_len | output | DW (32) | Byte count of the segment |
| xfer_src_fixed | output | 1 | Source address does not increment |
| xfer_dst_fixed | output | 1 | Destination address does not increment |
| xfer_src_unit | output | 8 | Source unit size in bytes |
| xfer_dst_unit | output | 8 | Destination unit size in bytes |
| xfer_done | input | 1 | Transfer datapath finished the segment |
| end_irq | output | 1 | End-of-segment interrupt pulse |

## Verification
The hardest case to reach is a ring that closes on itself. The walk must retire every entry, follow the last link back to the first entry, and then stop because that entry now reads as invalid. This works only if each write-back actually lands in memory before the re-fetch. The bench memory model applies every header write as it is seen. A three-entry ring is loaded with the last link pointing to the first entry, and the expected event queue ends with a bare eight-word re-fetch and nothing after it. A one-entry self-loop then places the write-back and the first re-fetch in the same cycle. A stray `start` is also injected mid-walk to show that it produces no extra reads.

// File: rtl/lnk_desc_pkg.sv
package lnk_desc_pkg;

  // descriptor geometry: eight words, fixed by the memory format
  localparam int NWORDS = 8;
  localparam int W_HDR  = 0;
  localparam int W_SRC  = 1;
  localparam int W_DST  = 2;
  localparam int W_LEN  = 3;
  localparam int W_CFG  = 4;
  localparam int W_ITVL = 5;
  localparam int W_EXT  = 6;
  localparam int W_NEXT = 7;

  // header and configuration bit positions decoded by this block
  localparam int HDR_VALID_BIT   = 0;
  localparam int CFG_LINK_BIT    = 31;
  localparam int CFG_IRQMASK_BIT = 24;
  localparam int CFG_DFIX_BIT    = 21;
  localparam int CFG_SFIX_BIT    = 20;
  localparam int CFG_DUNIT_LSB   = 16;
  localparam int CFG_SUNIT_LSB   = 12;

  localparam int SIZE_CODE_W = 4;
  localparam int SIZE_CODES  = 8;
  localparam int UNIT_W      = SIZE_CODES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_WAIT
  } walk_st_t;

  // unit size in bytes for a size code; codes past the table give zero
  function automatic logic [UNIT_W-1:0] unit_bytes(input logic [SIZE_CODE_W-1:0] code);
    if (code < SIZE_CODE_W'(SIZE_CODES))
      return UNIT_W'(1) << code[$clog2(SIZE_CODES)-1:0];
    return '0;
  endfunction

endpackage

// File: rtl/ldw_fetch_unit.sv
module ldw_fetch_unit
  import lnk_desc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic          rd_err,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] words [NWORDS],
  output logic [AW-1:0] base,
  output logic          done,
  output logic          err
);

  localparam int IDX_W = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [IDX_W-1:0] idx;
  logic             accept;

  assign accept = rd_req & rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      base    <= '0;
      idx     <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (go) begin
        rd_req  <= 1'b1;
        rd_addr <= go_addr;
        base    <= go_addr;
        idx     <= '0;
      end else if (accept) begin
        if (rd_err) begin
          rd_req <= 1'b0;
          err    <= 1'b1;
        end else begin
          rd_addr <= rd_addr + STEP;
          idx     <= idx + 1'b1;
          if (idx == LAST_IDX) begin
            rd_req <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  // word store: no reset, one write port, suits a small RAM
  always_ff @(posedge clk) begin
    if (accept && !rd_err)
      words[idx] <= rd_data;
  end

endmodule

// File: rtl/ldw_cfg_decode.sv
module ldw_cfg_decode
  import lnk_desc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     cfg,
  output logic              link_en,
  output logic              irq_en,
  output logic              src_fixed,
  output logic              dst_fixed,
  output logic [UNIT_W-1:0] src_unit,
  output logic [UNIT_W-1:0] dst_unit
);

  localparam int NSIDES = 2;
  localparam int SIDE_LSB [NSIDES] = '{CFG_SUNIT_LSB, CFG_DUNIT_LSB};

  logic [UNIT_W-1:0] units [NSIDES];
  logic              unused_cfg;

  for (genvar g = 0; g < NSIDES; g++) begin : g_unit
    assign units[g] = unit_bytes(cfg[SIDE_LSB[g] +: SIZE_CODE_W]);
  end

  assign src_unit   = units[0];
  assign dst_unit   = units[1];
  assign link_en    = cfg[CFG_LINK_BIT];
  assign irq_en     = ~cfg[CFG_IRQMASK_BIT];
  assign src_fixed  = cfg[CFG_SFIX_BIT];
  assign dst_fixed  = cfg[CFG_DFIX_BIT];
  assign unused_cfg = ^cfg;

endmodule

// File: rtl/lnk_desc_walker.sv
module lnk_desc_walker
  import lnk_desc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic              busy,
  output logic              err_flag,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_valid,
  input  logic              rd_err,
  input  logic [DW-1:0]     rd_data,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              xfer_start,
  output logic [DW-1:0]     xfer_src,
  output logic [DW-1:0]     xfer_dst,
  output logic [DW-1:0]     xfer_len,
  output logic              xfer_src_fixed,
  output logic              xfer_dst_fixed,
  output logic [UNIT_W-1:0] xfer_src_unit,
  output logic [UNIT_W-1:0] xfer_dst_unit,
  input  logic              xfer_done,
  output logic              end_irq
);

  localparam logic [DW-1:0] VALID_MASK = DW'(1) << HDR_VALID_BIT;

  walk_st_t          st;
  logic [DW-1:0]     words [NWORDS];
  logic [AW-1:0]     desc_base;
  logic [AW-1:0]     go_addr;
  logic              go, f_done, f_err;
  logic              hdr_valid, link_en, irq_en, sfix, dfix;
  logic [UNIT_W-1:0] sunit, dunit;
  logic              unused_words;

  assign hdr_valid = words[W_HDR][HDR_VALID_BIT];
  assign go        = ((st == ST_IDLE) && start) ||
                     ((st == ST_WAIT) && xfer_done && link_en);
  assign go_addr   = (st == ST_IDLE) ? start_addr : words[W_NEXT][AW-1:0];
  assign busy      = (st != ST_IDLE);
  assign unused_words = ^{words[W_ITVL], words[W_EXT]};

  ldw_fetch_unit #(.AW(AW), .DW(DW)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_addr  (go_addr),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_err   (rd_err),
    .rd_data  (rd_data),
    .words    (words),
    .base     (desc_base),
    .done     (f_done),
    .err      (f_err)
  );

  ldw_cfg_decode #(.DW(DW)) u_cfg (
    .cfg       (words[W_CFG]),
    .link_en   (link_en),
    .irq_en    (irq_en),
    .src_fixed (sfix),
    .dst_fixed (dfix),
    .src_unit  (sunit),
    .dst_unit  (dunit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      err_flag       <= 1'b0;
      wr_en          <= 1'b0;
      wr_addr        <= '0;
      wr_data        <= '0;
      end_irq        <= 1'b0;
      xfer_start     <= 1'b0;
      xfer_src       <= '0;
      xfer_dst       <= '0;
      xfer_len       <= '0;
      xfer_src_fixed <= 1'b0;
      xfer_dst_fixed <= 1'b0;
      xfer_src_unit  <= '0;
      xfer_dst_unit  <= '0;
    end else begin
      xfer_start <= 1'b0;
      wr_en      <= 1'b0;
      end_irq    <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            err_flag <= 1'b0;
            st       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (f_err) begin
            err_flag <= 1'b1;
            st       <= ST_IDLE;
          end else if (f_done) begin
            st <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (hdr_valid) begin
            xfer_start     <= 1'b1;
            xfer_src       <= words[W_SRC];
            xfer_dst       <= words[W_DST];
            xfer_len       <= words[W_LEN];
            xfer_src_fixed <= sfix;
            xfer_dst_fixed <= dfix;
            xfer_src_unit  <= sunit;
            xfer_dst_unit  <= dunit;
            st             <= ST_WAIT;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (xfer_done) begin
            wr_en   <= 1'b1;
            wr_addr <= desc_base;
            wr_data <= words[W_HDR] & ~VALID_MASK;
            end_irq <= irq_en;
            st      <= link_en ? ST_FETCH : ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lnk_desc_walker_chk.sv
module lnk_desc_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          err_flag,
  input logic          rd_req,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          wr_en,
  input logic          wr_bit0,
  input logic          xfer_start,
  input logic          end_irq
);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R3
  launch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  // R3
  launch_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> !rd_req);

  // R5
  retire_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !wr_bit0);

  // R6
  irq_with_retire_chk: assert property (@(posedge clk) disable iff (rst)
    end_irq |-> wr_en);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !start) |=> err_flag);

  // R11
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

endmodule

bind lnk_desc_walker lnk_desc_walker_chk #(.AW(AW)) u_walker_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .err_flag   (err_flag),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .rd_addr    (rd_addr),
  .wr_en      (wr_en),
  .wr_bit0    (wr_data[0]),
  .xfer_start (xfer_start),
  .end_irq    (end_irq)
);

// File: tb/lnk_desc_walker_bench.sv
module lnk_desc_walker_bench;

  localparam logic [31:0] C_LINK = 32'h8000_0000;
  localparam logic [31:0] C_MASK = 32'h0100_0000;
  localparam logic [31:0] C_DFIX = 32'h0020_0000;
  localparam logic [31:0] C_SFIX = 32'h0010_0000;
  localparam logic [1:0]  K_RD = 2'd0, K_XF = 2'd1, K_WB = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] a, b, c, d;
  } ev_t;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, err_flag, rd_req, wr_en, xfer_start, end_irq;
  logic [31:0] rd_addr, wr_addr, wr_data, xfer_src, xfer_dst, xfer_len;
  logic        rd_valid = 1'b0, rd_err = 1'b0, xfer_done = 1'b0;
  logic [31:0] rd_data = '0;
  logic        xfer_src_fixed, xfer_dst_fixed;
  logic [7:0]  xfer_src_unit, xfer_dst_unit;

  logic [31:0] mem [int unsigned];
  ev_t         q [$];
  ev_t         e;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  int          lat = 0, lat_cnt = 0, done_cnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  bit          finished = 0;

  always #5 clk = ~clk;

  lnk_desc_walker u_lnk_desc_walker (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .busy(busy), .err_flag(err_flag),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_err(rd_err), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_len(xfer_len), .xfer_src_fixed(xfer_src_fixed),
    .xfer_dst_fixed(xfer_dst_fixed), .xfer_src_unit(xfer_src_unit),
    .xfer_dst_unit(xfer_dst_unit), .xfer_done(xfer_done), .end_irq(end_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [7:0] unit_ref(input logic [3:0] c);
    return (c < 4'd8) ? (8'd1 << c[2:0]) : 8'd0;
  endfunction

  task automatic add_desc(input logic [31:0] base, hdr, sa, da, tb, cfg, nxt);
    mem[base] = hdr;      mem[base + 4] = sa;  mem[base + 8] = da;
    mem[base + 12] = tb;  mem[base + 16] = cfg;
    mem[base + 20] = 32'h1111_1111; mem[base + 24] = 32'h2222_2222;
    mem[base + 28] = nxt;
  endtask

  task automatic exp_reads(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) q.push_back('{K_RD, base + 32'(4 * i), 32'h0, 32'h0, 32'h0});
  endtask

  // expected events for one valid descriptor, from the requirements
  task automatic exp_run(input logic [31:0] base);
    logic [31:0] cfg;
    cfg = rdm(base + 16);
    exp_reads(base, 8);
    q.push_back('{K_XF, rdm(base + 4), rdm(base + 8), rdm(base + 12),
                  {14'b0, cfg[20], cfg[21], unit_ref(cfg[15:12]), unit_ref(cfg[19:16])}});
    q.push_back('{K_WB, base, rdm(base) & 32'hFFFF_FFFE, {31'b0, ~cfg[24]}, 32'h0});
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk);
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(!busy, req, 32'(busy), 32'h0);
    chk(q.size() == 0, {req, " all expected events seen"}, 32'(q.size()), 32'h0);
  endtask

  // monitor, memory and transfer-datapath responder
  always @(negedge clk) begin
    if (!rst) begin
      if (xfer_start) begin
        if (q.size() == 0) chk(0, "R4 unexpected transfer", xfer_src, 32'h0);
        else begin
          e = q.pop_front();
          chk(e.kind == K_XF, "R3 event order", 32'(e.kind), 32'(K_XF));
          chk(xfer_src == e.a, "R3 source", xfer_src, e.a);
          chk(xfer_dst == e.b, "R3 destination", xfer_dst, e.b);
          chk(xfer_len == e.c, "R3 length", xfer_len, e.c);
          chk({xfer_src_fixed, xfer_dst_fixed} == e.d[17:16], "R8 fixed flags",
              {30'b0, xfer_src_fixed, xfer_dst_fixed}, {30'b0, e.d[17:16]});
          chk({xfer_src_unit, xfer_dst_unit} == e.d[15:0], "R9 unit sizes",
              {16'b0, xfer_src_unit, xfer_dst_unit}, {16'b0, e.d[15:0]});
        end
        done_cnt = 3;
      end
      xfer_done = 1'b0;
      if (done_cnt > 0) begin
        done_cnt--;
        if (done_cnt == 0) xfer_done = 1'b1;
      end
      if (end_irq && !wr_en) chk(0, "R6 interrupt outside write-back", 32'h1, 32'h0);
      if (wr_en) begin
        if (q.size() == 0) chk(0, "R4 unexpected write-back", wr_addr, 32'h0);
        else begin
          e = q.pop_front();
          chk(e.kind == K_WB, "R5 event order", 32'(e.kind), 32'(K_WB));
          chk(wr_addr == e.a, "R5 write-back address", wr_addr, e.a);
          chk(wr_data == e.b, "R5 write-back data", wr_data, e.b);
          chk(32'(end_irq) == e.c, "R6 end interrupt", 32'(end_irq), e.c);
        end
        mem[wr_addr] = wr_data;
      end
      if (rd_valid) begin
        rd_valid = 1'b0;
        rd_err   = 1'b0;
        lat_cnt  = lat;
      end else if (rd_req) begin
        if (lat_cnt == 0) begin
          if (q.size() == 0) chk(0, "R2 unexpected read", rd_addr, 32'h0);
          else begin
            e = q.pop_front();
            chk(e.kind == K_RD, "R2 event order", 32'(e.kind), 32'(K_RD));
            chk(rd_addr == e.a, "R2 read address", rd_addr, e.a);
          end
          rd_valid = 1'b1;
          rd_data  = rdm(rd_addr);
          rd_err   = (rd_addr == err_addr);
        end else lat_cnt--;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs held low in reset
    chk(!busy && !err_flag && !rd_req && !wr_en && !xfer_start && !end_irq, "R1 reset state",
        {26'b0, busy, err_flag, rd_req, wr_en, xfer_start, end_irq}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_req, "R1 first cycle after reset", {30'b0, busy, rd_req}, 32'h0);

    // single descriptor, no link, interrupt enabled (R7 stop)
    lat = 0;
    add_desc(32'h100, 32'hA5A5_0001, 32'h1000_0000, 32'h2000_0000, 32'd64,
             (32'd2 << 12), 32'h900);
    exp_run(32'h100);
    pulse_start(32'h100);
    chk(busy, "R11 busy after start", 32'(busy), 32'h1);
    wait_idle("R7 stop without link");
    chk(mem[32'h100] == 32'hA5A5_0000, "R5 header retired in memory", mem[32'h100], 32'hA5A5_0000);

    // three-entry ring, stray start mid-walk, re-fetch of retired first entry
    lat = 2;
    add_desc(32'h200, 32'h0000_0003, 32'h3000_0000, 32'h4000_0000, 32'd16,
             C_LINK | C_MASK | C_SFIX | (32'd7 << 12) | (32'd9 << 16), 32'h300);
    add_desc(32'h300, 32'h0000_0101, 32'h3000_1000, 32'h4000_1000, 32'd32,
             C_LINK | C_MASK | C_DFIX | (32'd3 << 12) | (32'd1 << 16), 32'h240);
    add_desc(32'h240, 32'h8000_0001, 32'h3000_2000, 32'h4000_2000, 32'd8,
             C_LINK | (32'd0 << 12) | (32'd5 << 16), 32'h200);
    exp_run(32'h200);
    exp_run(32'h300);
    exp_run(32'h240);
    exp_reads(32'h200, 8);
    pulse_start(32'h200);
    repeat (4) @(negedge clk);
    pulse_start(32'h700); // R2: ignored while busy
    wait_idle("R7 ring follows link and halts on retired entry");
    chk(mem[32'h240] == 32'h8000_0000, "R5 last ring entry retired", mem[32'h240], 32'h8000_0000);

    // read error on the fourth word
    lat = 1;
    add_desc(32'h400, 32'h0000_0001, 32'h1, 32'h2, 32'd4, 32'h0, 32'h400);
    err_addr = 32'h40C;
    exp_reads(32'h400, 4);
    pulse_start(32'h400);
    wait_idle("R10 walk stops on read error");
    chk(err_flag, "R10 error flag set", 32'(err_flag), 32'h1);
    repeat (5) @(negedge clk);
    chk(err_flag, "R10 error flag sticky", 32'(err_flag), 32'h1);
    err_addr = 32'hFFFF_FFFF;

    // invalid descriptor: no transfer, no write-back, error cleared by start
    add_desc(32'h500, 32'h0000_0010, 32'h1, 32'h2, 32'd4, C_LINK, 32'h100);
    exp_reads(32'h500, 8);
    pulse_start(32'h500);
    chk(!err_flag, "R10 error cleared by start", 32'(err_flag), 32'h0);
    wait_idle("R4 halt on invalid header");
    chk(mem[32'h500] == 32'h0000_0010, "R4 invalid header untouched", mem[32'h500], 32'h10);

    // self-linked entry: write-back and re-fetch in the same cycle
    lat = 0;
    add_desc(32'h600, 32'h0000_00F1, 32'h5000_0000, 32'h6000_0000, 32'd128,
             C_LINK | (32'd15 << 12) | (32'd4 << 16), 32'h600);
    exp_run(32'h600);
    exp_reads(32'h600, 8);
    pulse_start(32'h600);
    wait_idle("R7 self link halts after one pass");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule